// File: doc/BRIEF.md
# Raster timing generator

The block produces the three raster strobes of a video stream (vertical sync, horizontal sync and data enable) from a single pixel clock. It also reports the column and line of each active pixel, so that a pattern source further down the pipeline can draw from those indices. Every duration and offset is a plain count of pixel clocks or pulses taken from static configuration inputs. Those inputs are loaded while the block is disabled.

Placement follows one scheme. The vertical strobe first appears after a one-time start delay and then repeats with a fixed high and low time. Each rising edge of the vertical strobe launches two pulse trains, one for horizontal sync and one for data enable. Each train waits an absolute number of pixel clocks measured from that edge, then emits a fixed number of pulses with programmable high and low widths. A rising edge on `enable` restarts the whole frame from the top, start delay included. Dropping `enable` silences every strobe at the next clock edge.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `vs_o`, `hs_o`, `de_o`, `pix_x` and `line_y` are all zero.
- R2: After the clock edge at which `enable` is first sampled high, `vs_o` stays low for exactly `vs_delay` cycles and then rises. With `vs_delay` = 0 it is high right after that edge. The start delay is applied only once per enable.
- R3: From its first rise, `vs_o` is high for `vs_high` cycles and low for `vs_low` cycles, and repeats with period `vs_high + vs_low` for as long as `enable` stays high.
- R4: At every rising edge of `vs_o`, the horizontal train waits `vs_to_hs` cycles and then emits `hs_count` pulses. Each pulse is `hs_high` cycles high followed by `hs_low` cycles low. With `vs_to_hs` = 0, `hs_o` rises in the same cycle as `vs_o`.
- R5: At every rising edge of `vs_o`, the data-enable train waits `vs_to_de` cycles and then emits `de_count` pulses. Each pulse is `de_high` cycles high followed by `de_low` cycles low.
- R6: While `de_o` is high, `pix_x` counts 0, 1, 2, … from the first cycle of the pulse. `line_y` holds the index of the current data-enable pulse within the frame, starting at 0 after each rising edge of `vs_o`. Both are zero whenever `de_o` is low.
- R7: When `enable` is sampled low, all five outputs are zero after that edge. A later rising edge of `enable` restarts the frame from its start delay.
- R8: A pulse count of zero (`hs_count` or `de_count`) keeps the corresponding strobe low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; a rising edge restarts the frame |
| vs_delay | input | 24 | One-time delay before the first vertical sync, in pixel clocks |
| vs_high | input | 24 | Vertical sync high time, in pixel clocks (at least 1) |
| vs_low | input | 24 | Vertical sync low time, in pixel clocks (at least 1) |
| vs_to_hs | input | 24 | Delay from the vertical sync rise to the first horizontal pulse |
| hs_high | input | 16 | Horizontal sync high width, in pixels (at least 1) |
| hs_low | input | 16 | Horizontal sync low width, in pixels (at least 1) |
| hs_count | input | 16 | Horizontal pulses per frame |
| vs_to_de | input | 24 | Delay from the vertical sync rise to the first data-enable pulse |
| de_high | input | 16 | Active pixels per line (at least 1) |
| de_low | input | 16 | Blanking pixels between active runs (at least 1) |
| de_count | input | 16 | Active lines per frame |
| vs_o | output | 1 | Vertical sync strobe |
| hs_o | output | 1 | Horizontal sync strobe |
| de_o | output | 1 | Data-enable strobe |
| pix_x | output | 16 | Column of the current active pixel |
| line_y | output | 16 | Line of the current active pixel |

## Verification
A corrupted phase counter or state in any pulse train shifts that strobe's edges in the same cycle. Because the bench compares every output on every cycle against a model computed from the configuration, the fault shows up at the first misplaced edge. A fault in the frame engine is more dangerous, because it moves all three strobes together. It is exposed at the first misplaced vertical edge, or one frame later when the period is wrong. Index faults appear as a wrong `pix_x` on the first active pixel, or as a wrong `line_y` on the second line of a frame.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    TG_IDLE  = 2'd0,
    TG_DELAY = 2'd1,
    TG_HIGH  = 2'd2,
    TG_LOW   = 2'd3
  } tg_state_e;

  function automatic int tg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tg_pulse_train.sv
// One delayed, counted pulse train: wait DLY cycles after launch, then emit
// NUM pulses of HI cycles high and LO cycles low (forever when endless).
module tg_pulse_train
  import tg_pkg::*;
#(
  parameter int DW = 24,
  parameter int WW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          launch,
  input  logic          endless,
  input  logic [DW-1:0] dly,
  input  logic [WW-1:0] hi,
  input  logic [WW-1:0] lo,
  input  logic [CW-1:0] num,
  output logic          high_nxt
);

  localparam int CTW = tg_max(DW, WW);

  tg_state_e      st_q, st_d;
  logic [CTW-1:0] cnt_q, cnt_d;
  logic [CW-1:0]  idx_q, idx_d;

  logic [CTW-1:0] dly_last, hi_last, lo_last;
  logic           more;

  always_comb begin
    dly_last = CTW'(dly) - CTW'(1);
    hi_last  = CTW'(hi)  - CTW'(1);
    lo_last  = CTW'(lo)  - CTW'(1);
    more     = endless || (({1'b0, idx_q} + (CW+1)'(1)) < {1'b0, num});
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (launch) begin
      cnt_d = '0;
      idx_d = '0;
      if (!endless && (num == '0))
        st_d = TG_IDLE;
      else if (dly == '0)
        st_d = TG_HIGH;
      else
        st_d = TG_DELAY;
    end else begin
      unique case (st_q)
        TG_DELAY: begin
          if (cnt_q == dly_last) begin
            st_d  = TG_HIGH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CTW'(1);
          end
        end
        TG_HIGH: begin
          if (cnt_q == hi_last) begin
            st_d  = TG_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CTW'(1);
          end
        end
        TG_LOW: begin
          if (cnt_q == lo_last) begin
            cnt_d = '0;
            if (more) begin
              st_d  = TG_HIGH;
              idx_d = idx_q + CW'(1);
            end else begin
              st_d = TG_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CTW'(1);
          end
        end
        default: st_d = TG_IDLE;
      endcase
    end
    if (!run) begin
      st_d  = TG_IDLE;
      cnt_d = '0;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TG_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign high_nxt = (st_d == TG_HIGH);

endmodule

// File: rtl/tg_index.sv
// Column and line counters for active pixels, cleared at each frame start.
module tg_index #(
  parameter int XW = 16,
  parameter int YW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          frame_rise,
  input  logic          de_rise,
  input  logic          de_nxt,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y
);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic          first_q, first_d;

  always_comb begin
    y_d     = y_q;
    first_d = first_q;
    if (frame_rise) begin
      y_d     = '0;
      first_d = 1'b1;
    end
    if (de_rise) begin
      if (first_d)
        first_d = 1'b0;
      else
        y_d = y_d + YW'(1);
    end
    if (de_rise)
      x_d = '0;
    else if (de_nxt)
      x_d = x_q + XW'(1);
    else
      x_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      x_q     <= '0;
      y_q     <= '0;
      first_q <= 1'b1;
      pix_x   <= '0;
      line_y  <= '0;
    end else begin
      x_q     <= x_d;
      y_q     <= y_d;
      first_q <= first_d;
      pix_x   <= de_nxt ? x_d : '0;
      line_y  <= de_nxt ? y_d : '0;
    end
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int TW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [TW-1:0] vs_delay,
  input  logic [TW-1:0] vs_high,
  input  logic [TW-1:0] vs_low,
  input  logic [TW-1:0] vs_to_hs,
  input  logic [SW-1:0] hs_high,
  input  logic [SW-1:0] hs_low,
  input  logic [SW-1:0] hs_count,
  input  logic [TW-1:0] vs_to_de,
  input  logic [SW-1:0] de_high,
  input  logic [SW-1:0] de_low,
  input  logic [SW-1:0] de_count,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic [SW-1:0] pix_x,
  output logic [SW-1:0] line_y
);

  logic en_q;
  logic start;
  logic vs_nxt, hs_nxt, de_nxt;
  logic vs_rise, de_rise;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enable;
  end

  assign start   = enable && !en_q;
  assign vs_rise = vs_nxt && !vs_o;
  assign de_rise = de_nxt && !de_o;

  // Frame engine: endless vertical pulses after a one-time delay.
  tg_pulse_train #(.DW(TW), .WW(TW), .CW(SW)) u_vs (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .launch   (start),
    .endless  (1'b1),
    .dly      (vs_delay),
    .hi       (vs_high),
    .lo       (vs_low),
    .num      ({SW{1'b0}}),
    .high_nxt (vs_nxt)
  );

  // Line sync train, relaunched at every vertical rise.
  tg_pulse_train #(.DW(TW), .WW(SW), .CW(SW)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .launch   (vs_rise),
    .endless  (1'b0),
    .dly      (vs_to_hs),
    .hi       (hs_high),
    .lo       (hs_low),
    .num      (hs_count),
    .high_nxt (hs_nxt)
  );

  // Active-video train, relaunched at every vertical rise.
  tg_pulse_train #(.DW(TW), .WW(SW), .CW(SW)) u_de (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .launch   (vs_rise),
    .endless  (1'b0),
    .dly      (vs_to_de),
    .hi       (de_high),
    .lo       (de_low),
    .num      (de_count),
    .high_nxt (de_nxt)
  );

  tg_index #(.XW(SW), .YW(SW)) u_idx (
    .clk        (clk),
    .rst        (rst),
    .run        (enable),
    .frame_rise (vs_rise),
    .de_rise    (de_rise),
    .de_nxt     (de_nxt),
    .pix_x      (pix_x),
    .line_y     (line_y)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      vs_o <= 1'b0;
      hs_o <= 1'b0;
      de_o <= 1'b0;
    end else begin
      vs_o <= vs_nxt;
      hs_o <= hs_nxt;
      de_o <= de_nxt;
    end
  end

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int TW = 24,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [TW-1:0] vs_to_hs,
  input logic [SW-1:0] hs_count,
  input logic          vs_o,
  input logic          hs_o,
  input logic          de_o,
  input logic [SW-1:0] pix_x,
  input logic [SW-1:0] line_y
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!vs_o && !hs_o && !de_o && pix_x == '0 && line_y == '0));

  p_hs_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(vs_o) && vs_to_hs == '0 && hs_count != '0) |-> hs_o);

  p_first_pixel_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(de_o) |-> (pix_x == '0));

  p_pixel_step_r6: assert property (@(posedge clk) disable iff (rst)
    (de_o && $past(de_o)) |-> (pix_x == $past(pix_x) + SW'(1)));

  p_blank_index_r6: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (pix_x == '0 && line_y == '0));

  p_disable_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!vs_o && !hs_o && !de_o));

  p_no_hs_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && hs_count == '0) |-> !hs_o);

endmodule

bind raster_timing_gen tg_checker #(.TW(TW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .vs_to_hs (vs_to_hs),
  .hs_count (hs_count),
  .vs_o     (vs_o),
  .hs_o     (hs_o),
  .de_o     (de_o),
  .pix_x    (pix_x),
  .line_y   (line_y)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;

  typedef struct {
    int vs_delay, vs_high, vs_low, vs_to_hs;
    int hs_high, hs_low, hs_count;
    int vs_to_de, de_high, de_low, de_count;
  } cfg_t;

  typedef struct {
    bit    vs, hs, de;
    int    x, y;
    int    t;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [23:0] vs_delay, vs_high, vs_low, vs_to_hs, vs_to_de;
  logic [15:0] hs_high, hs_low, hs_count, de_high, de_low, de_count;
  logic        vs_o, hs_o, de_o;
  logic [15:0] pix_x, line_y;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  cfg_t cfg;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .enable(enable),
    .vs_delay(vs_delay), .vs_high(vs_high), .vs_low(vs_low),
    .vs_to_hs(vs_to_hs), .hs_high(hs_high), .hs_low(hs_low),
    .hs_count(hs_count), .vs_to_de(vs_to_de), .de_high(de_high),
    .de_low(de_low), .de_count(de_count),
    .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o), .pix_x(pix_x), .line_y(line_y)
  );

  task automatic load_cfg(input cfg_t c);
    cfg      = c;
    vs_delay = 24'(c.vs_delay);
    vs_high  = 24'(c.vs_high);
    vs_low   = 24'(c.vs_low);
    vs_to_hs = 24'(c.vs_to_hs);
    hs_high  = 16'(c.hs_high);
    hs_low   = 16'(c.hs_low);
    hs_count = 16'(c.hs_count);
    vs_to_de = 24'(c.vs_to_de);
    de_high  = 16'(c.de_high);
    de_low   = 16'(c.de_low);
    de_count = 16'(c.de_count);
  endtask

  // Reference: output state t cycles after the enable-sampling edge.
  function automatic exp_t model(input int t, input cfg_t c, input string req);
    exp_t e;
    int u, p, q, per;
    e = '{vs: 1'b0, hs: 1'b0, de: 1'b0, x: 0, y: 0, t: t, req: req};
    u = t - c.vs_delay;
    if (u < 0) return e;
    p = u % (c.vs_high + c.vs_low);
    e.vs = (p < c.vs_high);
    q = p - c.vs_to_hs;
    per = c.hs_high + c.hs_low;
    if (q >= 0 && (q / per) < c.hs_count && (q % per) < c.hs_high) e.hs = 1'b1;
    q = p - c.vs_to_de;
    per = c.de_high + c.de_low;
    if (q >= 0 && (q / per) < c.de_count && (q % per) < c.de_high) begin
      e.de = 1'b1;
      e.x  = q % per;
      e.y  = q / per;
    end
    return e;
  endfunction

  function automatic exp_t quiet(input int t, input string req);
    exp_t e;
    e = '{vs: 1'b0, hs: 1'b0, de: 1'b0, x: 0, y: 0, t: t, req: req};
    return e;
  endfunction

  // Monitor: compare one expected item per falling edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      string tag;
      e = sb_q.pop_front();
      checks++;
      if (vs_o !== e.vs || hs_o !== e.hs || de_o !== e.de ||
          pix_x !== 16'(e.x) || line_y !== 16'(e.y)) begin
        errors++;
        if (e.req != "") tag = e.req;
        else if (vs_o !== e.vs) tag = "R2/R3";
        else if (hs_o !== e.hs) tag = "R4";
        else if (de_o !== e.de) tag = "R5";
        else tag = "R6";
        $display("FAIL %s t=%0d actual vs=%0b hs=%0b de=%0b x=%0d y=%0d expected vs=%0b hs=%0b de=%0b x=%0d y=%0d",
                 tag, e.t, vs_o, hs_o, de_o, pix_x, line_y, e.vs, e.hs, e.de, e.x, e.y);
      end
    end
  end

  // Driver: start a run and queue one expectation per cycle.
  task automatic run_frames(input int n, input string req);
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      sb_q.push_back(model(k, cfg, req));
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      sb_q.push_back(quiet(k, "R7"));
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cfg_t ca, cb;
    ca = '{vs_delay: 5, vs_high: 34, vs_low: 136, vs_to_hs: 0,
           hs_high: 3, hs_low: 14, hs_count: 10,
           vs_to_de: 92, de_high: 8, de_low: 9, de_count: 4};
    cb = '{vs_delay: 0, vs_high: 22, vs_low: 66, vs_to_hs: 2,
           hs_high: 2, hs_low: 9, hs_count: 0,
           vs_to_de: 30, de_high: 5, de_low: 6, de_count: 2};
    load_cfg(ca);

    // R1: quiet outputs while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (vs_o !== 1'b0 || hs_o !== 1'b0 || de_o !== 1'b0 || pix_x !== 16'd0 || line_y !== 16'd0) begin
      errors++;
      $display("FAIL R1 actual vs=%0b hs=%0b de=%0b x=%0d y=%0d expected all zero",
               vs_o, hs_o, de_o, pix_x, line_y);
    end
    rst = 1'b0;
    @(negedge clk);
    sb_q.push_back(quiet(0, "R1"));
    @(negedge clk);

    // R2 R3 R4 R5 R6: two full frames plus margin with a start delay
    run_frames(380, "");
    // R7: disable mid-frame
    stop_run();
    // R7: re-enable restarts from the start delay
    run_frames(120, "R7");
    stop_run();

    // R8: zero horizontal count, offset line sync, no start delay
    load_cfg(cb);
    @(negedge clk);
    run_frames(200, "");
    stop_run();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule